// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Serial Register Controller

This block is the device-side digital core of a two-channel, 10-bit voltage-output converter. A host drives three serial wires: an active-low frame select, a shift clock and a data line. The block oversamples them with its own system clock and collects a 16-bit command word. When the frame select returns high, it acts on the word. Each channel has two register stages. A staging register accepts new codes. An output register holds the code that the analog section converts.

A 4-bit opcode at the head of the word picks the action. It can load one staging register, load both with the same code, copy both staging registers into the output registers at the same time, enter the low-power state, or leave it. One opcode can combine several of these actions. Staging registers can be written while the device sleeps without waking it, so a later single command can wake the device and update both outputs. A frame with the wrong bit count is dropped and flagged.

Two state machines do the work. The frame machine has `FRM_IDLE` (select high) and `FRM_SHIFT` (select low, counting bits). It goes FRM_IDLE→FRM_SHIFT on a falling select edge and FRM_SHIFT→FRM_IDLE on a rising select edge; the second transition issues either an accept pulse or an error pulse. The power machine has `PWR_AWAKE` and `PWR_ASLEEP`. It goes PWR_AWAKE→PWR_ASLEEP on an accepted sleep opcode, and PWR_ASLEEP→PWR_AWAKE on an accepted opcode that carries a wake.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both output codes are zero, `sleep` is 0, both output enables are 1 and `frame_err` is 0.
- R2: Shift clock edges and data changes while `ser_cs_n` is high have no effect on the outputs and raise no error.
- R3: The word is taken MSB first. Bits 15..12 are the opcode, bits 11..2 are the 10-bit code (bit 11 = code MSB), and bits 1..0 are ignored.
- R4: No output changes while a frame is being shifted in. A command takes effect only after `ser_cs_n` rises at the end of a frame of exactly 16 bits.
- R5: Opcode 0001 loads staging register A and opcode 0010 loads staging register B. Neither changes an output code or the sleep state.
- R6: Opcode 1000 copies both staging registers into both output registers and wakes the device.
- R7: Opcode 1001 (or 1010) loads staging register A (or B) with the code, then copies both staging registers into the output registers and wakes the device.
- R8: Opcode 1111 loads the code into both staging registers, updates both output registers and wakes the device.
- R9: Opcode 1110 sets `sleep`, drives both output enables low and keeps all registers. Opcode 1101 clears `sleep` and changes no register.
- R10: Opcode 0000 and the reserved opcodes 0011 to 0111, 1011 and 1100 change nothing.
- R11: A frame ending after any bit count other than 16 changes no state and produces a `frame_err` pulse exactly one clock wide.
- R12: Loading a staging register (0001, 0010) while asleep leaves the device asleep with the output codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_cs_n | input | 1 | Serial frame select, active low; its rising edge executes the frame |
| ser_sck | input | 1 | Serial shift clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| code_a | output | DATA_W | Output register of channel A |
| code_b | output | DATA_W | Output register of channel B |
| sleep | output | 1 | High while in the low-power state |
| oe_a | output | 1 | Channel A drive enable; low means high impedance |
| oe_b | output | 1 | Channel B drive enable; low means high impedance |
| frame_err | output | 1 | One-cycle pulse when a frame had the wrong bit count |

## Verification
All sixteen opcodes are swept twice, once from the awake state and once from the sleep state. Before each command, the two staging registers are preloaded with codes that differ from each other and from the command's own code. This shows whether an update takes the new code, the existing staging value or the other channel's value, and whether loads keep the device asleep. Four code and pad patterns (all zeros, all ones and two alternating patterns) catch swapped or misaligned fields and any effect of the ignored bits. Frames of 0, 15 and 17 bits, and clock activity with the select high, check that bad or unselected traffic leaves every output unchanged.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam int CTRL_W = 4;
    localparam int NCH    = 2;

    localparam logic [CTRL_W-1:0] OP_NOP        = 4'h0;
    localparam logic [CTRL_W-1:0] OP_LD_A       = 4'h1;
    localparam logic [CTRL_W-1:0] OP_LD_B       = 4'h2;
    localparam logic [CTRL_W-1:0] OP_UPD        = 4'h8;
    localparam logic [CTRL_W-1:0] OP_LD_A_UPD   = 4'h9;
    localparam logic [CTRL_W-1:0] OP_LD_B_UPD   = 4'hA;
    localparam logic [CTRL_W-1:0] OP_WAKE       = 4'hD;
    localparam logic [CTRL_W-1:0] OP_SLEEP      = 4'hE;
    localparam logic [CTRL_W-1:0] OP_LD_ALL_UPD = 4'hF;

    typedef enum logic {FRM_IDLE, FRM_SHIFT} frm_state_e;
    typedef enum logic {PWR_AWAKE, PWR_ASLEEP} pwr_state_e;

    typedef struct packed {
        logic [NCH-1:0] load;
        logic           update;
        logic           wake;
        logic           sleep;
    } action_t;

    function automatic action_t decode_ctrl(input logic [CTRL_W-1:0] op);
        action_t a;
        a = '0;
        unique case (op)
            OP_LD_A:       a.load = 2'b01;
            OP_LD_B:       a.load = 2'b10;
            OP_UPD:        begin a.update = 1'b1; a.wake = 1'b1; end
            OP_LD_A_UPD:   begin a.load = 2'b01; a.update = 1'b1; a.wake = 1'b1; end
            OP_LD_B_UPD:   begin a.load = 2'b10; a.update = 1'b1; a.wake = 1'b1; end
            OP_WAKE:       a.wake = 1'b1;
            OP_SLEEP:      a.sleep = 1'b1;
            OP_LD_ALL_UPD: begin a.load = 2'b11; a.update = 1'b1; a.wake = 1'b1; end
            default:       a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign synced = stg_q[STAGES-1];

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import dac_ctrl_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int PAD_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              din,
    output logic              word_valid,
    output logic              frame_err,
    output logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] data
);

    localparam int WORD_W = CTRL_W + DATA_W + PAD_W;
    localparam int CNT_W  = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(WORD_W + 1);

    frm_state_e        state_q, state_d;
    logic              cs_prev_q, sck_prev_q;
    logic              cs_rise, cs_fall, sck_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              valid_q, err_q;

    assign cs_rise  =  cs_n & ~cs_prev_q;
    assign cs_fall  = ~cs_n &  cs_prev_q;
    assign sck_rise =  sck  & ~sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev_q  <= 1'b1;
            sck_prev_q <= 1'b0;
        end else begin
            cs_prev_q  <= cs_n;
            sck_prev_q <= sck;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRM_IDLE:  if (cs_fall) state_d = FRM_SHIFT;
            FRM_SHIFT: if (cs_rise) state_d = FRM_IDLE;
            default:   state_d = FRM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FRM_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            unique case (state_q)
                FRM_IDLE: begin
                    if (cs_fall) cnt_q <= '0;
                end
                FRM_SHIFT: begin
                    if (cs_rise) begin
                        valid_q <= (cnt_q == CNT_FULL);
                        err_q   <= (cnt_q != CNT_FULL);
                    end else if (sck_rise) begin
                        sh_q <= {sh_q[WORD_W-2:0], din};
                        if (cnt_q != CNT_CAP) cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign word_valid = valid_q;
    assign frame_err  = err_q;
    assign ctrl       = sh_q[WORD_W-1 -: CTRL_W];
    assign data       = sh_q[PAD_W +: DATA_W];

endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
    import dac_ctrl_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           word_valid,
    input  logic [CTRL_W-1:0]              ctrl,
    input  logic [DATA_W-1:0]              data,
    output logic [NCH-1:0][DATA_W-1:0]     dac_codes,
    output logic                           asleep
);

    action_t    act;
    pwr_state_e pwr_q, pwr_d;

    assign act = decode_ctrl(ctrl);

    always_comb begin
        pwr_d = pwr_q;
        if (word_valid) begin
            unique case (pwr_q)
                PWR_AWAKE:  if (act.sleep) pwr_d = PWR_ASLEEP;
                PWR_ASLEEP: if (act.wake)  pwr_d = PWR_AWAKE;
                default:    pwr_d = PWR_AWAKE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= PWR_AWAKE;
        else        pwr_q <= pwr_d;
    end

    assign asleep = (pwr_q == PWR_ASLEEP);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [DATA_W-1:0] stage_q, stage_d, out_q;

        assign stage_d = (word_valid && act.load[ch]) ? data : stage_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                out_q   <= '0;
            end else begin
                stage_q <= stage_d;
                if (word_valid && act.update) out_q <= stage_d;
            end
        end

        assign dac_codes[ch] = out_q;
    end

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int PAD_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_cs_n,
    input  logic              ser_sck,
    input  logic              ser_din,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              sleep,
    output logic              oe_a,
    output logic              oe_b,
    output logic              frame_err
);

    logic [2:0]                    pins_s;
    logic                          frm_valid;
    logic [CTRL_W-1:0]             frm_ctrl;
    logic [DATA_W-1:0]             frm_data;
    logic [NCH-1:0][DATA_W-1:0]    codes;
    logic                          asleep;

    bit_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({ser_din, ser_sck, ser_cs_n}),
        .synced(pins_s)
    );

    frame_shifter #(
        .DATA_W(DATA_W),
        .PAD_W (PAD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (pins_s[0]),
        .sck       (pins_s[1]),
        .din       (pins_s[2]),
        .word_valid(frm_valid),
        .frame_err (frame_err),
        .ctrl      (frm_ctrl),
        .data      (frm_data)
    );

    cmd_exec #(
        .DATA_W(DATA_W)
    ) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(frm_valid),
        .ctrl      (frm_ctrl),
        .data      (frm_data),
        .dac_codes (codes),
        .asleep    (asleep)
    );

    assign code_a = codes[0];
    assign code_b = codes[1];
    assign sleep  = asleep;
    assign oe_a   = ~asleep;
    assign oe_b   = ~asleep;

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_valid,
    input logic              frame_err,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              sleep,
    input logic              oe_a,
    input logic              oe_b
);

    // R4: outputs move only in the cycle after an accepted frame
    p_codes_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> ($stable(code_a) && $stable(code_b)));

    // R11: error pulse is a single cycle
    p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    // R11: a rejected frame is never also accepted
    p_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && word_valid));

    // R11: rejected frame leaves state untouched
    p_err_no_change_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> ($stable(code_a) && $stable(code_b) && $stable(sleep)));

    // R12: power state changes only on an accepted command
    p_sleep_by_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(sleep));

    // R9: both channels released to high impedance while asleep
    p_hiz_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!oe_a && !oe_b));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_valid(frm_valid),
    .frame_err (frame_err),
    .code_a    (code_a),
    .code_b    (code_b),
    .sleep     (sleep),
    .oe_a      (oe_a),
    .oe_b      (oe_b)
);

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb;

    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          din = 1'b0;
    logic [DW-1:0] code_a, code_b;
    logic          sleep, oe_a, oe_b, frame_err;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;
    bit            m_slp = 1'b0;

    always #10 clk = ~clk;

    dual_dac_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_sck(sck), .ser_din(din),
        .code_a(code_a), .code_b(code_b), .sleep(sleep),
        .oe_a(oe_a), .oe_b(oe_b), .frame_err(frame_err)
    );

    always @(negedge clk) if (rst_n && frame_err) err_seen++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        checks++;
        if (code_a !== m_dac_a || code_b !== m_dac_b || sleep !== m_slp ||
            oe_a !== !m_slp || oe_b !== !m_slp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h slp=%b oe=%b%b expected a=%h b=%h slp=%b oe=%b%b",
                     tag, code_a, code_b, sleep, oe_a, oe_b,
                     m_dac_a, m_dac_b, m_slp, !m_slp, !m_slp);
        end
    endtask

    task automatic check_err(input string tag, input int exp);
        checks++;
        if (err_seen != exp) begin
            errors++;
            $display("FAIL %s: error pulses=%0d expected %0d", tag, err_seen, exp);
        end
    endtask

    task automatic shift_in(input logic [31:0] w, input int n);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            din = w[n-1-i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic raise_cs();
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    function automatic void model(input logic [3:0] op, input logic [DW-1:0] d);
        case (op)
            4'h1: m_in_a = d;
            4'h2: m_in_b = d;
            4'h8: begin m_dac_a = m_in_a; m_dac_b = m_in_b; m_slp = 0; end
            4'h9: begin m_in_a = d; m_dac_a = m_in_a; m_dac_b = m_in_b; m_slp = 0; end
            4'hA: begin m_in_b = d; m_dac_a = m_in_a; m_dac_b = m_in_b; m_slp = 0; end
            4'hD: m_slp = 0;
            4'hE: m_slp = 1;
            4'hF: begin m_in_a = d; m_in_b = d; m_dac_a = d; m_dac_b = d; m_slp = 0; end
            default: ;
        endcase
    endfunction

    function automatic string tag_of(input int op, input bit was_asleep);
        case (op)
            1, 2:    return was_asleep ? "R12" : "R5";
            8:       return "R6";
            9, 10:   return "R7";
            15:      return "R8";
            13, 14:  return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic send_cmd(input logic [3:0] op, input logic [DW-1:0] d,
                            input logic [1:0] pad, input string tag);
        int e0;
        e0 = err_seen;
        shift_in({16'h0, op, d, pad}, 16);
        raise_cs();
        model(op, d);
        check_state(tag);
        check_err("R11 good frame", e0);
    endtask

    initial begin
        logic [DW-1:0] d_pat [4] = '{10'h000, 10'h3FF, 10'h155, 10'h2AA};
        logic [DW-1:0] a_pat [4] = '{10'h3C1, 10'h012, 10'h2E7, 10'h0F0};
        logic [DW-1:0] b_pat [4] = '{10'h21D, 10'h18B, 10'h063, 10'h30F};
        int e0;

        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(4);
        check_state("R1 reset");
        check_err("R1 reset", 0);

        // R2: clocking with select high
        for (int i = 0; i < 6; i++) begin
            din = i[0];
            wait_clk(3);
            sck = 1'b1;
            wait_clk(3);
            sck = 1'b0;
        end
        wait_clk(8);
        check_state("R2 idle clocks");
        check_err("R2 idle clocks", 0);

        for (int pass = 0; pass < 2; pass++) begin
            for (int op = 0; op < 16; op++) begin
                for (int p = 0; p < 4; p++) begin
                    bit was;
                    if (pass == 1) send_cmd(4'hE, d_pat[p], 2'(p), "R9");
                    send_cmd(4'h1, a_pat[p], 2'(3 - p), tag_of(1, m_slp));
                    send_cmd(4'h2, b_pat[p], 2'(p), tag_of(2, m_slp));
                    was = m_slp;
                    e0 = err_seen;
                    shift_in({16'h0, 4'(op), d_pat[p], 2'(p)}, 16);
                    check_state("R4 before select rises");
                    raise_cs();
                    model(4'(op), d_pat[p]);
                    check_state(tag_of(op, was));
                    check_err("R11 good frame", e0);
                end
            end
        end

        // R3: field alignment with ignored pad bits set
        send_cmd(4'hF, 10'h201, 2'b11, "R3");
        send_cmd(4'h9, 10'h004, 2'b01, "R3");

        // R11: wrong bit counts
        e0 = err_seen;
        shift_in(32'h0000_F155 >> 1, 15);
        raise_cs();
        check_state("R11 15 bits");
        check_err("R11 15 bits", e0 + 1);
        shift_in({15'h0, 17'h1_E2AA}, 17);
        raise_cs();
        check_state("R11 17 bits");
        check_err("R11 17 bits", e0 + 2);
        shift_in(32'h0, 0);
        raise_cs();
        check_state("R11 0 bits");
        check_err("R11 0 bits", e0 + 3);

        // R9 then R12 then wake via update
        send_cmd(4'hE, 10'h000, 2'b00, "R9");
        send_cmd(4'h1, 10'h123, 2'b00, "R12");
        send_cmd(4'h2, 10'h321, 2'b00, "R12");
        send_cmd(4'h8, 10'h000, 2'b00, "R6");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule